// File: doc/BRIEF.md
# Dual-Sampler Eye-Centering Tracker

This block keeps the primary sampling delay of a serial receive lane near the middle of the data eye while ordinary traffic is flowing. No training pattern is needed. Next to the primary sampler there is a monitor sampler. Its delay tap swings between a fixed offset above the primary tap and the same offset below it. Each position is held for a dwell of valid words, and the block compares the two sampled words. If the monitor disagrees at one side only, that side is near an eye edge, so the primary tap steps one tap away from it. Agreement on both sides leaves the primary tap where it is. Disagreement on both sides means the eye is too narrow for the offset, and a status flag is raised.

Each tap change is followed by a short settling window, during which comparisons are ignored. The tracker never stops, so it follows slow voltage and temperature drift. The delay lines, deserializers and word alignment are outside the block. They take the tap values and load strobes and return the two sampled words with a valid strobe.

Top module: `eye_centre_tracker`

## Requirements
- R1: On reset the primary tap is TAP_INIT (16) and the monitor tap is TAP_INIT+OFFSET (18). Both load strobes and eye_closed_o are low.
- R2: The monitor dwells first at the plus side, then at the minus side, and then alternates. Its tap is min(n+OFFSET,31) during a plus dwell and max(n−OFFSET,0) during a minus dwell, where n is the primary tap. mon_load_o pulses for one cycle in the same cycle that each new monitor tap appears.
- R3: A dwell ends on its 256th counted valid word. Words presented with valid_i low are neither counted nor compared.
- R4: For 8 cycles after reset and after every mon_load_o pulse, comparisons are suppressed and no word is counted.
- R5: If any one counted word in a dwell differs from the primary word in any bit, a mismatch is recorded for that side.
- R6: At the end of each minus dwell the block decides. With no mismatch on either side the tap stays. With a plus mismatch only, n decreases by 1. With a minus mismatch only, n increases by 1. prim_load_o pulses together with mon_load_o whenever n changes.
- R7: If both sides mismatch within one dither period, n is unchanged and eye_closed_o goes high. The flag clears at the end of the next period that does not mismatch on both sides.
- R8: The primary tap saturates at 0 and at 31. A saturated step gives no prim_load_o, and the monitor tap is clamped to the same range.
- R9: The primary tap changes by at most one step per dither period (one plus dwell and one minus dwell), and tracking continues indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sampled words are valid this cycle |
| prim_data_i | input | DATA_W | Word from the primary sampler |
| mon_data_i | input | DATA_W | Word from the monitor sampler |
| prim_tap_o | output | TAP_W | Primary delay tap |
| mon_tap_o | output | TAP_W | Monitor delay tap |
| prim_load_o | output | 1 | One-cycle strobe: load prim_tap_o |
| mon_load_o | output | 1 | One-cycle strobe: load mon_tap_o |
| eye_closed_o | output | 1 | Both sides mismatched in the last decided period |

## Verification
The bench uses the default parameters: 5-bit taps, start tap 16, offset 2, dwell 256 and settle 8. With these values a dither period is 528 cycles when valid is held high, so both saturation limits can be reached by forced one-sided mismatches within about sixteen periods. A model of the eye window in the bench lets the tap move in both directions and stop at a centre. It also covers the narrow-eye case, a single-word glitch, and valid gaps that hold garbage data.

// File: rtl/eye_trk_pkg.sv
package eye_trk_pkg;
  typedef enum logic {
    SIDE_PLUS  = 1'b0,
    SIDE_MINUS = 1'b1
  } side_e;
endpackage

// File: rtl/eye_trk_settle.sv
module eye_trk_settle #(
  parameter int SETTLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  output logic busy_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CW'(SETTLE);
    else if (reload_i)      cnt_q <= CW'(SETTLE);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eye_trk_dwell.sv
module eye_trk_dwell #(
  parameter int DATA_W = 10,
  parameter int DWELL  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] prim_data_i,
  input  logic [DATA_W-1:0] mon_data_i,
  output logic              done_o,
  output logic              mis_o
);
  localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [DW_W-1:0] cnt_q;
  logic            acc_q;
  logic            count_en, diff, last;

  assign count_en = valid_i & ~hold_i;
  assign diff     = (prim_data_i != mon_data_i);
  assign last     = (cnt_q == DW_W'(DWELL - 1));
  assign done_o   = count_en & last;
  // sticky result including the word that closes the dwell
  assign mis_o    = acc_q | (count_en & diff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (count_en) begin
      if (last) begin
        cnt_q <= '0;
        acc_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= acc_q | diff;
      end
    end
  end

  // R3
  dwell_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en |=> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/eye_trk_ctrl.sv
module eye_trk_ctrl
  import eye_trk_pkg::*;
#(
  parameter int TAP_W    = 5,
  parameter int OFFSET   = 2,
  parameter int TAP_INIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             mis_i,
  output logic [TAP_W-1:0] prim_tap_o,
  output logic [TAP_W-1:0] mon_tap_o,
  output logic             prim_load_o,
  output logic             mon_load_o,
  output logic             eye_closed_o
);
  localparam int TAP_MAX = (1 << TAP_W) - 1;

  function automatic logic [TAP_W-1:0] clamp_tap(input int v);
    if (v < 0)       return '0;
    if (v > TAP_MAX) return TAP_W'(TAP_MAX);
    return TAP_W'(v);
  endfunction

  side_e            side_q;
  logic [TAP_W-1:0] prim_q, mon_q, prim_nx;
  logic             mis_plus_q, prim_load_q, mon_load_q, closed_q;

  always_comb begin
    prim_nx = prim_q;
    if (mis_plus_q && !mis_i)      prim_nx = clamp_tap(int'(prim_q) - 1);
    else if (!mis_plus_q && mis_i) prim_nx = clamp_tap(int'(prim_q) + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_q      <= SIDE_PLUS;
      prim_q      <= clamp_tap(TAP_INIT);
      mon_q       <= clamp_tap(TAP_INIT + OFFSET);
      mis_plus_q  <= 1'b0;
      prim_load_q <= 1'b0;
      mon_load_q  <= 1'b0;
      closed_q    <= 1'b0;
    end else begin
      mon_load_q  <= done_i;
      prim_load_q <= 1'b0;
      if (done_i) begin
        if (side_q == SIDE_PLUS) begin
          side_q     <= SIDE_MINUS;
          mis_plus_q <= mis_i;
          mon_q      <= clamp_tap(int'(prim_q) - OFFSET);
        end else begin
          side_q      <= SIDE_PLUS;
          mis_plus_q  <= 1'b0;
          prim_q      <= prim_nx;
          mon_q       <= clamp_tap(int'(prim_nx) + OFFSET);
          prim_load_q <= (prim_nx != prim_q);
          closed_q    <= mis_plus_q & mis_i;
        end
      end
    end
  end

  assign prim_tap_o   = prim_q;
  assign mon_tap_o    = mon_q;
  assign prim_load_o  = prim_load_q;
  assign mon_load_o   = mon_load_q;
  assign eye_closed_o = closed_q;

  // R9
  prim_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_q != $past(prim_q)) |->
      ((int'(prim_q) - int'($past(prim_q)) == 1) || (int'($past(prim_q)) - int'(prim_q) == 1)));
  // R2
  mon_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(mon_q) - int'(prim_q) <= OFFSET) && (int'(prim_q) - int'(mon_q) <= OFFSET)));
  // R6
  prim_load_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_load_q |-> mon_load_q);
  // R7
  closed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(closed_q) |-> (!prim_load_q && mon_load_q));
endmodule

// File: rtl/eye_centre_tracker.sv
module eye_centre_tracker #(
  parameter int DATA_W   = 10,
  parameter int TAP_W    = 5,
  parameter int OFFSET   = 2,
  parameter int TAP_INIT = 16,
  parameter int DWELL    = 256,
  parameter int SETTLE   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] prim_data_i,
  input  logic [DATA_W-1:0] mon_data_i,
  output logic [TAP_W-1:0]  prim_tap_o,
  output logic [TAP_W-1:0]  mon_tap_o,
  output logic              prim_load_o,
  output logic              mon_load_o,
  output logic              eye_closed_o
);
  logic settle_busy, dwell_done, dwell_mis;

  eye_trk_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (dwell_done),
    .busy_o   (settle_busy)
  );

  eye_trk_dwell #(.DATA_W(DATA_W), .DWELL(DWELL)) u_dwell (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .hold_i      (settle_busy),
    .prim_data_i (prim_data_i),
    .mon_data_i  (mon_data_i),
    .done_o      (dwell_done),
    .mis_o       (dwell_mis)
  );

  eye_trk_ctrl #(.TAP_W(TAP_W), .OFFSET(OFFSET), .TAP_INIT(TAP_INIT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (dwell_done),
    .mis_i        (dwell_mis),
    .prim_tap_o   (prim_tap_o),
    .mon_tap_o    (mon_tap_o),
    .prim_load_o  (prim_load_o),
    .mon_load_o   (mon_load_o),
    .eye_closed_o (eye_closed_o)
  );

  // R4
  settle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_busy |-> !dwell_done);
endmodule

// File: tb/sim_eye_centre_tracker.sv
`timescale 1ns/1ps
module sim_eye_centre_tracker;
  localparam int DW = 10;
  localparam int TW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b1;
  logic [DW-1:0] prim_data_i = '0;
  logic [DW-1:0] mon_data_i;
  logic [TW-1:0] prim_tap_o, mon_tap_o;
  logic          prim_load_o, mon_load_o, eye_closed_o;

  int   n_chk = 0, n_bad = 0;
  int   mode = 0, eye_lo = 0, eye_hi = 31;
  logic force_bad = 1'b0, gap = 1'b0, model_bad;

  always #2.5 clk_i = ~clk_i;

  // eye model: 0 window, 1 plus side bad, 2 minus side bad
  always_comb begin
    case (mode)
      1:       model_bad = (mon_tap_o > prim_tap_o);
      2:       model_bad = (mon_tap_o < prim_tap_o);
      default: model_bad = (int'(mon_tap_o) < eye_lo) || (int'(mon_tap_o) > eye_hi);
    endcase
  end
  assign mon_data_i = prim_data_i ^ {{(DW-1){1'b0}}, (force_bad | (gap & ~valid_i) | model_bad)};

  eye_centre_tracker u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .prim_data_i(prim_data_i), .mon_data_i(mon_data_i),
    .prim_tap_o(prim_tap_o), .mon_tap_o(mon_tap_o),
    .prim_load_o(prim_load_o), .mon_load_o(mon_load_o),
    .eye_closed_o(eye_closed_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; force_bad = 1'b0; gap = 1'b0; valid_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // steps until the next mon_load_o; cyc = edges since the last load or reset
  task automatic wait_load(input int bad_until, input int glitch_at, input bit use_gap,
                           output int cyc);
    cyc = 0; gap = use_gap; force_bad = (bad_until > 0); valid_i = use_gap ? 1'b0 : 1'b1;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (mon_load_o) break;
      force_bad = (cyc < bad_until) || (cyc == glitch_at);
      valid_i   = use_gap ? cyc[0] : 1'b1;
      prim_data_i = prim_data_i + 1'b1;
    end
    force_bad = 1'b0; gap = 1'b0; valid_i = 1'b1;
  endtask

  task automatic run_period();
    int c;
    wait_load(0, 0, 1'b0, c);
    wait_load(0, 0, 1'b0, c);
  endtask

  task automatic t_reset_and_dither();
    int c;
    mode = 0; eye_lo = 0; eye_hi = 31;
    do_reset();
    chk(prim_tap_o == 5'd16, "R1", prim_tap_o, 16);
    chk(mon_tap_o == 5'd18, "R1", mon_tap_o, 18);
    chk(!prim_load_o && !mon_load_o && !eye_closed_o, "R1",
        {prim_load_o, mon_load_o, eye_closed_o}, 0);
    wait_load(0, 0, 1'b0, c);
    chk(c == 264, "R3", c, 264);
    chk(mon_tap_o == 5'd14, "R2", mon_tap_o, 14);
    chk(prim_load_o == 1'b0, "R2", prim_load_o, 0);
    @(negedge clk_i);
    chk(mon_load_o == 1'b0, "R2", mon_load_o, 0);
    wait_load(0, 0, 1'b0, c);
    chk(c == 263, "R3", c, 263);
    chk(prim_tap_o == 5'd16 && !prim_load_o, "R6", prim_tap_o, 16);
    chk(mon_tap_o == 5'd18, "R2", mon_tap_o, 18);
  endtask

  task automatic t_settle();
    int c;
    mode = 0; eye_lo = 0; eye_hi = 31;
    do_reset();
    wait_load(8, 0, 1'b0, c);
    wait_load(8, 0, 1'b0, c);
    chk(prim_tap_o == 5'd16 && !eye_closed_o, "R4", prim_tap_o, 16);
  endtask

  task automatic t_glitch();
    int c;
    mode = 0; eye_lo = 0; eye_hi = 31;
    do_reset();
    wait_load(0, 100, 1'b0, c);
    wait_load(0, 0, 1'b0, c);
    chk(prim_tap_o == 5'd15, "R5", prim_tap_o, 15);
    chk(prim_load_o == 1'b1, "R6", prim_load_o, 1);
    chk(mon_tap_o == 5'd17, "R2", mon_tap_o, 17);
  endtask

  task automatic t_gaps();
    int c;
    mode = 0; eye_lo = 0; eye_hi = 31;
    do_reset();
    wait_load(0, 0, 1'b1, c);
    chk(c == 520, "R3", c, 520);
    wait_load(0, 0, 1'b1, c);
    chk(prim_tap_o == 5'd16, "R3", prim_tap_o, 16);
  endtask

  task automatic t_track(input int lo, input int hi, input int e0, input int e1,
                         input int e2, input int e3);
    int exp_q[4];
    exp_q = '{e0, e1, e2, e3};
    mode = 0; eye_lo = lo; eye_hi = hi;
    do_reset();
    foreach (exp_q[i]) begin
      run_period();
      chk(int'(prim_tap_o) == exp_q[i], "R9", prim_tap_o, exp_q[i]);
    end
    chk(!prim_load_o, "R6", prim_load_o, 0);
  endtask

  task automatic t_closed();
    mode = 0; eye_lo = 16; eye_hi = 16;
    do_reset();
    run_period();
    chk(eye_closed_o == 1'b1, "R7", eye_closed_o, 1);
    chk(prim_tap_o == 5'd16 && !prim_load_o, "R7", prim_tap_o, 16);
    eye_lo = 0; eye_hi = 31;
    run_period();
    chk(eye_closed_o == 1'b0, "R7", eye_closed_o, 0);
  endtask

  task automatic t_sat_low();
    int c;
    mode = 1;
    do_reset();
    for (int i = 0; i < 16; i++) run_period();
    chk(prim_tap_o == 5'd0, "R8", prim_tap_o, 0);
    chk(mon_tap_o == 5'd2, "R8", mon_tap_o, 2);
    wait_load(0, 0, 1'b0, c);
    chk(mon_tap_o == 5'd0, "R8", mon_tap_o, 0);
    wait_load(0, 0, 1'b0, c);
    chk(prim_tap_o == 5'd0 && !prim_load_o, "R8", prim_tap_o, 0);
    mode = 0;
  endtask

  task automatic t_sat_high();
    int c;
    mode = 2;
    do_reset();
    for (int i = 0; i < 15; i++) run_period();
    chk(prim_tap_o == 5'd31, "R8", prim_tap_o, 31);
    chk(mon_tap_o == 5'd31, "R8", mon_tap_o, 31);
    wait_load(0, 0, 1'b0, c);
    chk(mon_tap_o == 5'd29, "R8", mon_tap_o, 29);
    wait_load(0, 0, 1'b0, c);
    chk(prim_tap_o == 5'd31 && !prim_load_o, "R8", prim_tap_o, 31);
    mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_and_dither();
    t_settle();
    t_glitch();
    t_gaps();
    t_track(17, 28, 17, 18, 19, 19); // drift up
    t_track(3, 15, 15, 14, 13, 13);  // drift down
    t_closed();
    t_sat_low();
    t_sat_high();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule